// File: doc/BRIEF.md
# Two-Channel Pin Control Register Block

This block gives software control of up to two groups of general-purpose pins through a 32-bit AXI4-Lite slave port. Each group (channel) is between 1 and 32 pins wide and owns two registers: a value register and a direction register. The direction register decides, pin by pin, whether the block drives the pin or only observes it. Its contents go straight out on a per-pin tri-state control so that a pad buffer outside the block can act on them.

Incoming pin levels pass through a two-stage synchronizer. The synchronized levels feed register readback and are also brought out on their own port so that a separate change detector can use them. The second channel is a build-time option. When it is left out, its registers are still decoded, but they behave as holes in the map.

Top module: `gpio_regs`

## Requirements
- R1: On the first cycle after a synchronous active-low reset, each value register holds its parameter default, each direction register holds its parameter default, `chN_out` and `chN_tri` show those values, and `s_bvalid` and `s_rvalid` are 0.
- R2: The direction register of a channel sits at word offset 0x04 (channel 1) or 0x0C (channel 2). It reads back as written, and `chN_tri` equals it: a 1 bit makes the pin an input and a 0 bit makes it an output.
- R3: A read of a value register (offset 0x00 for channel 1, 0x08 for channel 2) returns the synchronized pin level in every bit whose direction is input, and 0 in every bit whose direction is output.
- R4: A write to a value register changes only the bits whose direction is output, and `chN_out` shows the new value. Bits whose direction is input keep their previous stored value.
- R5: Writes use all 32 bits of `s_wdata` whatever the value of `s_wstrb`.
- R6: With `DUAL_EN` = 0, writes to offsets 0x08 and 0x0C change nothing, reads from them return 0, `ch2_tri` is all ones and `ch2_out` is all zeros.
- R7: Every write and read response is OKAY (0). An address with any bit set from bit 4 upward is unmapped: reading it returns 0 and writing it changes no register.
- R8: Register bits at or above the channel's configured width read as 0 and take no write data.
- R9: `chN_sync` equals `chN_in` as it was two clock edges earlier, and register readback uses this synchronized value.
- R10: A write is accepted (`s_awready` = `s_wready` = 1) only in a cycle where `s_awvalid` and `s_wvalid` are both high and no write response is pending. A valid address alone is never accepted.
- R11: Once raised, `s_bvalid` stays high until `s_bready`. Once raised, `s_rvalid` stays high with `s_rdata` unchanged until `s_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte strobes, ignored |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| ch1_in | input | CH1_W | Channel 1 pin levels |
| ch1_out | output | CH1_W | Channel 1 drive values |
| ch1_tri | output | CH1_W | Channel 1 tri-state control, 1 = input |
| ch1_sync | output | CH1_W | Channel 1 synchronized pin levels |
| ch2_in | input | CH2_W | Channel 2 pin levels |
| ch2_out | output | CH2_W | Channel 2 drive values |
| ch2_tri | output | CH2_W | Channel 2 tri-state control, 1 = input |
| ch2_sync | output | CH2_W | Channel 2 synchronized pin levels |

## Verification
The assertions assume that the manager keeps `s_awvalid` and `s_arvalid` low during reset and holds `s_bready` and `s_rready` low until a response is present. They also assume that pin levels are sampled only at clock edges, so the two-edge synchronizer delay can be checked exactly. The stimulus meets these assumptions:
- every bus signal and pin is driven on the falling edge;
- each transaction starts only after the previous response has been taken;
- pin values are held for at least two edges before a readback.

The sweeps step through every direction pattern and every pin pattern of a small configuration (5 and 3 bits wide).

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Word selector inside the 16-byte register window; the order is fixed by the map.
    typedef enum logic [1:0] {
        SEL_VAL1 = 2'd0,
        SEL_DIR1 = 2'd1,
        SEL_VAL2 = 2'd2,
        SEL_DIR2 = 2'd3
    } reg_sel_e;

    localparam int WIN_LSB  = 4;
    localparam int SEL_LSB  = 2;
    localparam logic [1:0] RESP_OK = 2'b00;

    typedef struct packed {
        logic        bvalid;
        logic        rvalid;
        logic [31:0] rdata;
    } bus_st_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.s2;
endmodule

// File: rtl/gpio_chan.sv
module gpio_chan #(
    parameter int          W       = 8,
    parameter logic [31:0] VAL_RST = 32'h0,
    parameter logic [31:0] DIR_RST = 32'hFFFF_FFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_val,
    input  logic         we_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] val_q_o,
    output logic [W-1:0] dir_q_o,
    output logic [31:0]  rd_val,
    output logic [31:0]  rd_dir
);
    typedef struct packed {
        logic [W-1:0] val;
        logic [W-1:0] dir;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        // input-direction bits keep their stored value; output bits take the bus data
        if (we_val) ch_d.val = (ch_q.val & ch_q.dir) | (wdata & ~ch_q.dir);
        if (we_dir) ch_d.dir = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q.val <= VAL_RST[W-1:0];
            ch_q.dir <= DIR_RST[W-1:0];
        end else begin
            ch_q <= ch_d;
        end
    end

    assign val_q_o = ch_q.val;
    assign dir_q_o = ch_q.dir;
    assign rd_val  = 32'(pin_sync & ch_q.dir);
    assign rd_dir  = 32'(ch_q.dir);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter bit          DUAL_EN  = 1'b1,
    parameter int          CH1_W    = 32,
    parameter int          CH2_W    = 32,
    parameter logic [31:0] CH1_VAL_RST = 32'h0,
    parameter logic [31:0] CH1_DIR_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] CH2_VAL_RST = 32'h0,
    parameter logic [31:0] CH2_DIR_RST = 32'hFFFF_FFFF,
    parameter int          ADDR_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [CH1_W-1:0]  ch1_in,
    output logic [CH1_W-1:0]  ch1_out,
    output logic [CH1_W-1:0]  ch1_tri,
    output logic [CH1_W-1:0]  ch1_sync,
    input  logic [CH2_W-1:0]  ch2_in,
    output logic [CH2_W-1:0]  ch2_out,
    output logic [CH2_W-1:0]  ch2_tri,
    output logic [CH2_W-1:0]  ch2_sync
);
    bus_st_t  st_d, st_q;
    logic     wr_fire, rd_fire, w_mapped, r_mapped;
    reg_sel_e w_sel, r_sel;
    logic     we_val1, we_dir1, we_val2, we_dir2;
    logic [31:0] rd_val1, rd_dir1, rd_val2, rd_dir2, rd_mux;
    logic     unused_bus;

    assign unused_bus = ^{s_wstrb, s_wdata, s_awaddr[SEL_LSB-1:0], s_araddr[SEL_LSB-1:0]};

    // address decode
    assign w_mapped = (s_awaddr[ADDR_W-1:WIN_LSB] == '0);
    assign r_mapped = (s_araddr[ADDR_W-1:WIN_LSB] == '0);
    assign w_sel    = reg_sel_e'(s_awaddr[WIN_LSB-1:SEL_LSB]);
    assign r_sel    = reg_sel_e'(s_araddr[WIN_LSB-1:SEL_LSB]);

    assign wr_fire  = s_awvalid & s_wvalid & ~st_q.bvalid;
    assign rd_fire  = s_arvalid & ~st_q.rvalid;

    assign we_val1  = wr_fire & w_mapped & (w_sel == SEL_VAL1);
    assign we_dir1  = wr_fire & w_mapped & (w_sel == SEL_DIR1);
    assign we_val2  = wr_fire & w_mapped & (w_sel == SEL_VAL2);
    assign we_dir2  = wr_fire & w_mapped & (w_sel == SEL_DIR2);

    gpio_sync #(.W(CH1_W)) u_sync1 (
        .clk(clk), .rst_n(rst_n), .pin_in(ch1_in), .pin_sync(ch1_sync)
    );

    gpio_chan #(.W(CH1_W), .VAL_RST(CH1_VAL_RST), .DIR_RST(CH1_DIR_RST)) u_chan1 (
        .clk(clk), .rst_n(rst_n), .we_val(we_val1), .we_dir(we_dir1),
        .wdata(s_wdata[CH1_W-1:0]), .pin_sync(ch1_sync),
        .val_q_o(ch1_out), .dir_q_o(ch1_tri), .rd_val(rd_val1), .rd_dir(rd_dir1)
    );

    generate
        if (DUAL_EN) begin : g_ch2
            gpio_sync #(.W(CH2_W)) u_sync2 (
                .clk(clk), .rst_n(rst_n), .pin_in(ch2_in), .pin_sync(ch2_sync)
            );
            gpio_chan #(.W(CH2_W), .VAL_RST(CH2_VAL_RST), .DIR_RST(CH2_DIR_RST)) u_chan2 (
                .clk(clk), .rst_n(rst_n), .we_val(we_val2), .we_dir(we_dir2),
                .wdata(s_wdata[CH2_W-1:0]), .pin_sync(ch2_sync),
                .val_q_o(ch2_out), .dir_q_o(ch2_tri), .rd_val(rd_val2), .rd_dir(rd_dir2)
            );
        end else begin : g_no_ch2
            logic unused_ch2;
            assign unused_ch2 = ^{ch2_in, we_val2, we_dir2};
            assign ch2_out  = '0;
            assign ch2_tri  = '1;
            assign ch2_sync = '0;
            assign rd_val2  = '0;
            assign rd_dir2  = '0;
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        if (r_mapped) begin
            unique case (r_sel)
                SEL_VAL1: rd_mux = rd_val1;
                SEL_DIR1: rd_mux = rd_dir1;
                SEL_VAL2: rd_mux = rd_val2;
                SEL_DIR2: rd_mux = rd_dir2;
                default:  rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.bvalid && s_bready) st_d.bvalid = 1'b0;
        if (wr_fire)                 st_d.bvalid = 1'b1;
        if (st_q.rvalid && s_rready) st_d.rvalid = 1'b0;
        if (rd_fire) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_bvalid  = st_q.bvalid;
    assign s_bresp   = RESP_OK;
    assign s_arready = rd_fire;
    assign s_rvalid  = st_q.rvalid;
    assign s_rdata   = st_q.rdata;
    assign s_rresp   = RESP_OK;
endmodule

// File: rtl/gpio_regs_chk.sv
module gpio_regs_chk #(
    parameter int CH1_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_awvalid,
    input logic             s_wvalid,
    input logic             s_awready,
    input logic             s_bvalid,
    input logic             s_bready,
    input logic [1:0]       s_bresp,
    input logic             s_rvalid,
    input logic             s_rready,
    input logic [31:0]      s_rdata,
    input logic [1:0]       s_rresp,
    input logic [CH1_W-1:0] ch1_in,
    input logic [CH1_W-1:0] ch1_sync,
    input logic [CH1_W-1:0] ch1_out,
    input logic [CH1_W-1:0] ch1_tri
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_AW_NEEDS_W: assert property (@(posedge clk) disable iff (!rst_n)
        s_awready |-> (s_awvalid && s_wvalid)); // R10
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid); // R11
    AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R11
    AST_BRESP_OK: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> (s_bresp == 2'b00)); // R7
    AST_RRESP_OK: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> (s_rresp == 2'b00)); // R7
    AST_TRI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s_awvalid && s_awready) |-> $stable(ch1_tri)); // R2
    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s_awvalid && s_awready) |-> $stable(ch1_out)); // R4
    AST_SYNC_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (ch1_sync == $past(ch1_in, 2))); // R9
endmodule

bind gpio_regs gpio_regs_chk #(.CH1_W(CH1_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_awvalid(s_awvalid), .s_wvalid(s_wvalid),
    .s_awready(s_awready), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .ch1_in(ch1_in), .ch1_sync(ch1_sync), .ch1_out(ch1_out), .ch1_tri(ch1_tri)
);

// File: tb/gpio_regs_bench.sv
module gpio_regs_bench;
    localparam int W1 = 5;
    localparam int W2 = 3;
    localparam logic [31:0] V1R = 32'h0A, D1R = 32'h13, V2R = 32'h5, D2R = 32'h7;
    localparam logic [31:0] M1 = 32'h1F, M2 = 32'h7;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [8:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic [W1-1:0] ch1_in = '0;
    logic [W2-1:0] ch2_in = '0;

    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic [W1-1:0] ch1_out, ch1_tri, ch1_sync;
    logic [W2-1:0] ch2_out, ch2_tri, ch2_sync;

    logic sawready, swready, sbvalid, sarready, srvalid;
    logic [1:0] sbresp, srresp;
    logic [31:0] srdata;
    logic [W1-1:0] sch1_out, sch1_tri, sch1_sync;
    logic [W2-1:0] sch2_out, sch2_tri, sch2_sync;

    gpio_regs #(.DUAL_EN(1'b1), .CH1_W(W1), .CH2_W(W2), .CH1_VAL_RST(V1R), .CH1_DIR_RST(D1R),
                .CH2_VAL_RST(V2R), .CH2_DIR_RST(D2R), .ADDR_W(9)) u_gpio_regs (
        .clk(clk), .rst_n(rst_n), .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .ch1_in(ch1_in), .ch1_out(ch1_out), .ch1_tri(ch1_tri), .ch1_sync(ch1_sync),
        .ch2_in(ch2_in), .ch2_out(ch2_out), .ch2_tri(ch2_tri), .ch2_sync(ch2_sync));

    gpio_regs #(.DUAL_EN(1'b0), .CH1_W(W1), .CH2_W(W2), .CH1_VAL_RST(V1R), .CH1_DIR_RST(D1R),
                .CH2_VAL_RST(V2R), .CH2_DIR_RST(D2R), .ADDR_W(9)) u_gpio_regs_single (
        .clk(clk), .rst_n(rst_n), .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(sawready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(swready),
        .s_bresp(sbresp), .s_bvalid(sbvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(sarready),
        .s_rdata(srdata), .s_rresp(srresp), .s_rvalid(srvalid), .s_rready(rready),
        .ch1_in(ch1_in), .ch1_out(sch1_out), .ch1_tri(sch1_tri), .ch1_sync(sch1_sync),
        .ch2_in(ch2_in), .ch2_out(sch2_out), .ch2_tri(sch2_tri), .ch2_sync(sch2_sync));

    int n_total = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] m_val1 = V1R, m_dir1 = D1R, m_val2 = V2R, m_dir2 = D2R;
    logic [31:0] rd_m, rd_s;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        #1 check("R10 awready with both valids", {31'd0, awready & wready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        check("R7 bvalid+bresp", {29'd0, bvalid, bresp}, 32'h4);
        bready = 1;
        @(posedge clk);
        @(negedge clk);
        bready = 0;
        check("R11 bvalid drops after bready", {31'd0, bvalid}, 32'd0);
    endtask

    task automatic axi_rd(input logic [8:0] a);
        @(negedge clk);
        araddr = a; arvalid = 1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        check("R7 rvalid+rresp", {29'd0, rvalid, rresp}, 32'h4);
        rd_m = rdata; rd_s = srdata;
        rready = 1;
        @(posedge clk);
        @(negedge clk);
        rready = 0;
    endtask

    // bench model of a value-register write
    function automatic logic [31:0] upd(input logic [31:0] v, input logic [31:0] dir,
                                        input logic [31:0] d, input logic [31:0] m);
        return ((v & dir) | (d & ~dir)) & m;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 ch1_out", 32'(ch1_out), V1R);
        check("R1 ch1_tri", 32'(ch1_tri), D1R);
        check("R1 ch2_out", 32'(ch2_out), V2R);
        check("R1 ch2_tri", 32'(ch2_tri), D2R);
        check("R1 bvalid/rvalid", {30'd0, bvalid, rvalid}, 32'd0);
        axi_rd(9'h04);
        check("R1 dir1 readback", rd_m, D1R);

        // R9 synchronizer delay
        repeat (3) @(negedge clk);
        ch1_in = 5'h15;
        @(posedge clk); @(negedge clk);
        check("R9 sync after one edge", 32'(ch1_sync), 32'h0);
        @(posedge clk); @(negedge clk);
        check("R9 sync after two edges", 32'(ch1_sync), 32'h15);
        axi_rd(9'h00);
        check("R3 R9 readback of synced pins", rd_m, 32'h15 & D1R);

        // R4 R5 R8: write with zero strobes and upper junk
        axi_wr(9'h00, 32'hFFFF_FFE5, 4'h0);
        m_val1 = upd(m_val1, m_dir1, 32'hFFFF_FFE5, M1);
        check("R4 R5 input bits kept", 32'(ch1_out), m_val1);
        axi_wr(9'h04, 32'hFFFF_FFFF, 4'h0);
        m_dir1 = M1;
        axi_rd(9'h04);
        check("R8 R5 dir1 upper bits zero", rd_m, M1);

        // R2 R3 R4 sweep over every direction and pin pattern of channel 1
        for (int d = 0; d < 32; d++) begin
            axi_wr(9'h04, 32'(d), 4'hF);
            m_dir1 = 32'(d);
            check("R2 ch1_tri", 32'(ch1_tri), m_dir1);
            axi_wr(9'h00, 32'(d * 7 + 3), 4'h1);
            m_val1 = upd(m_val1, m_dir1, 32'(d * 7 + 3), M1);
            check("R4 ch1_out after write", 32'(ch1_out), m_val1);
            for (int p = 0; p < 32; p++) begin
                @(negedge clk);
                ch1_in = W1'(p);
                repeat (2) @(negedge clk);
                axi_rd(9'h00);
                check("R3 ch1 value read", rd_m, 32'(p) & m_dir1);
            end
        end

        // channel 2 on the dual instance, R6 on the single instance
        check("R6 single ch2_tri", 32'(sch2_tri), 32'h7);
        for (int d = 0; d < 8; d++) begin
            axi_wr(9'h0C, 32'(d), 4'hF);
            m_dir2 = 32'(d);
            check("R2 ch2_tri", 32'(ch2_tri), m_dir2);
            axi_wr(9'h08, 32'(d ^ 5), 4'hF);
            m_val2 = upd(m_val2, m_dir2, 32'(d ^ 5), M2);
            check("R4 ch2_out", 32'(ch2_out), m_val2);
            check("R6 single ch2_out", 32'(sch2_out), 32'h0);
            check("R6 single ch2_tri after write", 32'(sch2_tri), 32'h7);
            axi_rd(9'h0C);
            check("R2 ch2 dir read", rd_m, m_dir2);
            check("R6 single dir2 read", rd_s, 32'h0);
            for (int p = 0; p < 8; p++) begin
                @(negedge clk);
                ch2_in = W2'(p);
                repeat (2) @(negedge clk);
                axi_rd(9'h08);
                check("R3 ch2 value read", rd_m, 32'(p) & m_dir2);
                check("R6 single val2 read", rd_s, 32'h0);
            end
        end

        // R7 unmapped addresses
        axi_wr(9'h010, 32'h0, 4'hF);
        axi_wr(9'h104, 32'h0, 4'hF);
        axi_rd(9'h04);
        check("R7 dir1 untouched", rd_m, m_dir1);
        check("R7 ch1_out untouched", 32'(ch1_out), m_val1);
        axi_rd(9'h114);
        check("R7 unmapped read", rd_m, 32'h0);

        // R10 address without data is not accepted
        @(negedge clk);
        awaddr = 9'h04; wdata = 32'h0; awvalid = 1;
        #1 check("R10 lone awvalid", {31'd0, awready}, 32'd0);
        @(posedge clk); @(negedge clk);
        check("R10 no response", {31'd0, bvalid}, 32'd0);
        awvalid = 0;
        axi_rd(9'h04);
        check("R10 dir1 unchanged", rd_m, m_dir1);

        // R11 response holding
        @(negedge clk);
        araddr = 9'h04; arvalid = 1;
        @(posedge clk); @(negedge clk);
        arvalid = 0;
        rd_m = rdata;
        repeat (3) @(negedge clk);
        check("R11 rvalid held", {31'd0, rvalid}, 32'd1);
        check("R11 rdata held", rdata, rd_m);
        rready = 1;
        @(posedge clk); @(negedge clk);
        rready = 0;
        awaddr = 9'h04; wdata = m_dir1; awvalid = 1; wvalid = 1;
        @(posedge clk); @(negedge clk);
        awvalid = 0; wvalid = 0;
        repeat (3) @(negedge clk);
        check("R11 bvalid held", {31'd0, bvalid}, 32'd1);
        bready = 1;
        @(posedge clk); @(negedge clk);
        bready = 0;
        check("R11 bvalid released", {31'd0, bvalid}, 32'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end
endmodule